// File: doc/BRIEF.md
# SPI Transmit/Receive Interrupt Threshold Generator

This block produces the transmit and receive interrupt requests of a byte-oriented SPI controller. A 3-bit mode field picks a single threshold that serves both directions. On the transmit side, a counter tallies the per-byte strobes coming from the shifter. When the tally reaches the threshold, the block raises a sticky interrupt flag and restarts the count. On the receive side, the block compares the occupancy level of an 8-entry receive FIFO against the same threshold every cycle.

Codes 0 to 6 select a threshold of code+1 bytes. Code 7 selects 8 bytes for transmit, and for receive it turns the threshold into a FIFO-full test. A controller that feeds received bytes to DMA runs with code 0, which interrupts after every byte. The mode input is captured in a register that resets to code 0. A disable input clears the transmit count and masks the receive request.

Top module: `spi_irq_thresh`

## Requirements
- R1: While reset is asserted, `tx_irq_o` is 0, the transmit count is 0 and the captured mode is code 0. With `en_i`=1 and `rx_level_i`=1, `rx_irq_o` is therefore 1 during reset whatever `mode_i` is.
- R2: With captured code c, `tx_irq_o` rises at the clock edge that counts byte strobe number c+1 since the count last restarted. Code 7 means 8 strobes. The count restarts at zero on that same edge.
- R3: `tx_irq_o` stays set until an edge where `tx_ack_i`=1 clears it. If the threshold is reached on the same edge as an acknowledge, the flag stays set.
- R4: For captured codes 0 to 6, `rx_irq_o` is 1 exactly when `en_i`=1 and `rx_level_i` >= code+1. The output follows `rx_level_i` in the same cycle.
- R5: For captured code 7, `rx_irq_o` is 1 only when `en_i`=1 and `rx_level_i` equals 8.
- R6: While `en_i`=0, `rx_irq_o` is 0, byte strobes are ignored and the transmit count is held at zero. An already set `tx_irq_o` keeps its value.
- R7: `mode_i` is captured on each clock edge, and the captured value applies from the next byte counted. If the bytes already counted reach the new threshold, the next strobe raises `tx_irq_o`.
- R8: A byte strobe that leaves the count below the threshold does not change `tx_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Controller enable |
| mode_i | input | 3 | Interrupt threshold code |
| byte_done_i | input | 1 | One-cycle strobe per byte shifted out |
| rx_level_i | input | 4 | Receive FIFO occupancy, 0 to 8 |
| tx_ack_i | input | 1 | One-cycle acknowledge clearing the transmit flag |
| tx_irq_o | output | 1 | Sticky transmit interrupt request |
| rx_irq_o | output | 1 | Level receive interrupt request |

## Verification
The assertions check the following on every cycle:
- the transmit flag holds until it is acknowledged;
- an acknowledge with no strobe clears the flag;
- the flag never rises without a counted strobe;
- the receive request is masked when disabled and is never raised on an empty FIFO;
- a full FIFO always raises the receive request.

Some behaviour depends on the mode and on the history of the count, so only the bench scenarios can show it:
- the exact strobe on which each code fires;
- the FIFO-full rule of code 7;
- clearing of the count on disable;
- a threshold lowered in the middle of a count.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned DEF_MODE_W     = 3;
  localparam int unsigned DEF_FIFO_DEPTH = 8;
endpackage

// File: rtl/spi_irq_tx_cnt.sv
module spi_irq_tx_cnt #(
  parameter int unsigned MODE_W = 3,
  localparam int unsigned CNT_W = MODE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              byte_done_i,
  input  logic              ack_i,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc, thresh;
  logic             hit, irq_q;

  always_comb begin
    thresh  = {1'b0, mode_i} + CNT_W'(1);
    cnt_inc = cnt_q + CNT_W'(1);
    // >= so a threshold lowered mid-count fires on the next byte
    hit     = en_i & byte_done_i & (cnt_inc >= thresh);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (!en_i || hit)     cnt_q <= '0;
      else if (byte_done_i) cnt_q <= cnt_inc;
      if (hit)        irq_q <= 1'b1;
      else if (ack_i) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/spi_irq_rx_cmp.sv
module spi_irq_rx_cmp #(
  parameter int unsigned MODE_W = 3,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned LVL_W  = 4,
  localparam int unsigned NUM_CODES = 1 << MODE_W
) (
  input  logic              en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [LVL_W-1:0]  level_i,
  output logic              irq_o
);
  logic [NUM_CODES-1:0] hit;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    if (g == NUM_CODES - 1) begin : g_full
      assign hit[g] = (mode_i == MODE_W'(g)) && (level_i == LVL_W'(DEPTH));
    end else begin : g_thr
      assign hit[g] = (mode_i == MODE_W'(g)) && (level_i >= LVL_W'(g + 1));
    end
  end

  assign irq_o = en_i & (|hit);
endmodule

// File: rtl/spi_irq_thresh.sv
module spi_irq_thresh
  import spi_irq_pkg::*;
#(
  parameter int unsigned MODE_W = DEF_MODE_W,
  parameter int unsigned DEPTH  = DEF_FIFO_DEPTH,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              byte_done_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic              tx_ack_i,
  output logic              tx_irq_o,
  output logic              rx_irq_o
);
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else         mode_q <= mode_i;
  end

  spi_irq_tx_cnt #(.MODE_W(MODE_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .mode_i      (mode_q),
    .byte_done_i (byte_done_i),
    .ack_i       (tx_ack_i),
    .irq_o       (tx_irq_o)
  );

  spi_irq_rx_cmp #(.MODE_W(MODE_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_rx (
    .en_i    (en_i),
    .mode_i  (mode_q),
    .level_i (rx_level_i),
    .irq_o   (rx_irq_o)
  );
endmodule

// File: rtl/spi_irq_thresh_chk.sv
module spi_irq_thresh_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LVL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             byte_done_i,
  input logic [LVL_W-1:0] rx_level_i,
  input logic             tx_ack_i,
  input logic             tx_irq_o,
  input logic             rx_irq_o
);
  // R3
  a_r3_tx_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o && !tx_ack_i |=> tx_irq_o);
  // R3
  a_r3_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ack_i && !byte_done_i |=> !tx_irq_o);
  // R8
  a_r8_no_spurious_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_irq_o && !(byte_done_i && en_i) |=> !tx_irq_o);
  // R6
  a_r6_rx_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !rx_irq_o);
  // R4
  a_r4_rx_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> rx_level_i != '0);
  // R5
  a_r5_full_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && rx_level_i == LVL_W'(DEPTH) |-> rx_irq_o);
endmodule

bind spi_irq_thresh spi_irq_thresh_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .byte_done_i (byte_done_i),
  .rx_level_i  (rx_level_i),
  .tx_ack_i    (tx_ack_i),
  .tx_irq_o    (tx_irq_o),
  .rx_irq_o    (rx_irq_o)
);

// File: tb/spi_irq_thresh_tb.sv
module spi_irq_thresh_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {mode[8:6], level[5:2], en[1], expected rx[0]}
  localparam logic [8:0] RX_VEC [NVEC] = '{
    {3'd0, 4'd0, 1'b1, 1'b0}, {3'd0, 4'd1, 1'b1, 1'b1},
    {3'd1, 4'd1, 1'b1, 1'b0}, {3'd2, 4'd2, 1'b1, 1'b0},
    {3'd2, 4'd3, 1'b1, 1'b1}, {3'd4, 4'd5, 1'b1, 1'b1},
    {3'd6, 4'd6, 1'b1, 1'b0}, {3'd6, 4'd7, 1'b1, 1'b1},
    {3'd6, 4'd8, 1'b1, 1'b1}, {3'd7, 4'd7, 1'b1, 1'b0},
    {3'd7, 4'd8, 1'b1, 1'b1}, {3'd3, 4'd8, 1'b0, 1'b0}
  };

  logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0, byte_done = 1'b0, ack = 1'b0;
  logic [2:0] mode = '0;
  logic [3:0] level = '0;
  logic       tx_irq, rx_irq;
  int         checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_thresh u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
    .byte_done_i(byte_done), .rx_level_i(level), .tx_ack_i(ack),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) byte_done = 1'b1;
      @(negedge clk) byte_done = 1'b0;
    end
  endtask

  task automatic do_ack();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk) mode = m;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    mode = 3'd7; level = 4'd1; en = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_irq, 1'b0, "R1", "tx in reset");
    chk(rx_irq, 1'b1, "R1", "rx uses code 0 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_irq, 1'b0, "R5", "code 7 captured, level 1");

    // R4 R5 R6: receive table
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      mode = RX_VEC[v][8:6]; level = RX_VEC[v][5:2]; en = RX_VEC[v][1];
      @(negedge clk);
      chk(rx_irq, RX_VEC[v][0], (RX_VEC[v][8:6] == 3'd7) ? "R5" :
          (RX_VEC[v][1] ? "R4" : "R6"), $sformatf("rx vec %0d", v));
    end
    en = 1'b1; level = '0;

    // R2 R3 R8: each code fires on strobe code+1
    for (int c = 0; c < 8; c++) begin
      set_mode(3'(c));
      if (c > 0) begin
        send(c);
        chk(tx_irq, 1'b0, "R8", $sformatf("code %0d below threshold", c));
      end
      send(1);
      chk(tx_irq, 1'b1, "R2", $sformatf("code %0d at threshold", c));
      do_ack();
      chk(tx_irq, 1'b0, "R3", $sformatf("code %0d ack", c));
    end

    // R3: threshold and ack on the same edge
    set_mode(3'd0);
    send(1);
    @(negedge clk) begin byte_done = 1'b1; ack = 1'b1; end
    @(negedge clk) begin byte_done = 1'b0; ack = 1'b0; end
    chk(tx_irq, 1'b1, "R3", "set wins over ack");
    do_ack();

    // R6: disable clears count, ignores strobes, keeps flag
    set_mode(3'd3);
    send(2);
    @(negedge clk) en = 1'b0; level = 4'd8;
    send(3);
    chk(tx_irq, 1'b0, "R6", "strobes ignored when off");
    chk(rx_irq, 1'b0, "R6", "rx masked when off");
    @(negedge clk) en = 1'b1; level = '0;
    send(3);
    chk(tx_irq, 1'b0, "R6", "count restarted after off");
    send(1);
    chk(tx_irq, 1'b1, "R6", "fires after 4 fresh strobes");
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    chk(tx_irq, 1'b1, "R6", "flag kept while off");
    @(negedge clk) en = 1'b1;
    do_ack();

    // R7: threshold lowered mid-count
    set_mode(3'd5);
    send(4);
    set_mode(3'd1);
    chk(tx_irq, 1'b0, "R7", "no fire on mode change alone");
    send(1);
    chk(tx_irq, 1'b1, "R7", "lowered threshold fires next byte");
    do_ack();
    // R7: threshold raised mid-count
    set_mode(3'd1);
    send(1);
    set_mode(3'd3);
    send(2);
    chk(tx_irq, 1'b0, "R7", "raised threshold not yet");
    send(1);
    chk(tx_irq, 1'b1, "R7", "raised threshold at 4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule